// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a two-wire serial memory holding 256 bytes, arranged as 16 pages of 16 bytes each. A fast system clock oversamples the clock line (SCL) and data line (SDA). Each line passes through a two-flop synchronizer and a glitch filter. The filtered lines drive edge detectors that find START and STOP conditions. A byte-level state machine then does four jobs: it matches the device address, acknowledges bytes, loads write data into a page buffer, and serves read data from a register array. SDA is open-drain. The block never drives SDA high. It only asserts an output enable that pulls the line low.

A host writes by sending the address byte with R/W=0, then one byte address, then one or more data bytes, then STOP. The data sits in a page buffer until a valid STOP arrives on a byte boundary. At that point the buffer is written into the array and a programming interval begins. During this interval the block ignores the bus completely. A host reads in one of two ways. It can address the device with R/W=1 directly, which continues from the internal pointer. Or it can set the pointer with a write-direction address phase, then issue a repeated START with R/W=1.

Top module: `twi_mem_target`

## Requirements
- R1: The block acknowledges an address byte only when its bits [7:4] equal 1010 and its bits [3:1] equal {A2,A1,A0} taken from `strap_i[2:0]`. Bit 0 is R/W, where 1 means read. Bytes travel MSB first. An acknowledge is SDA held low during the ninth clock. On a mismatch, the block stays silent until the next START.
- R2: A write of one data byte takes effect in the array only after the STOP that ends it. A later read of that address returns the byte.
- R3: In a multi-byte write, each data byte goes to the next offset within the page selected by byte-address bits [7:4]. The offset is the low 4 bits and wraps from 15 to 0, so data beyond 16 bytes overwrites earlier bytes of the same page.
- R4: For `WR_CYCLES` system clocks after a committing STOP, the block acknowledges nothing and leaves SDA released. After that interval it responds again.
- R5: A write-direction address phase, followed by a repeated START with R/W=1, reads from the byte address just sent.
- R6: A read with no address phase continues from the internal pointer. The pointer advances after every byte sent and wraps from 255 to 0.
- R7: When the host NACKs a read byte and then sends STOP, the read ends with SDA released, and the block answers the next transfer normally.
- R8: Several events discard the received write data and start no programming interval: a STOP arriving partway through a byte, or a repeated START arriving during a write.
- R9: A pulse on SCL or SDA lasting fewer than `FILT_LEN` system clocks has no effect on the protocol.
- R10: The block changes its SDA drive only while SCL is low.
- R11: After reset, SDA is released and every array byte reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired level) |
| strap_i | input | 3 | Address strap levels {A2,A1,A0} |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench sweeps all eight strap combinations and several wrong type codes. A decoder that swaps strap bits, or that ignores the type code, would acknowledge the wrong bytes. A page write of 18 bytes that starts mid-page must leave the two overrun bytes at the start offset. A design that carries the overflow into the next page would corrupt a neighbouring page instead. A three-byte read starting at address 254 has to wrap to 0. A STOP placed four bits into a byte, and a repeated START after a data byte, must both leave the array unchanged and the device immediately responsive. A design that commits partial data, or starts its busy interval anyway, would return stale reads or drop the acknowledge. A two-clock SDA dip while SCL is high must not register as a START, or the address byte would go unanswered.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } twi_state_t;

   typedef enum logic [1:0] {
      K_DEV,
      K_ADDR,
      K_DATA
   } twi_kind_t;

endpackage

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
   parameter int FILT_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   localparam int CW = $clog2(FILT_LEN + 1);

   logic [1:0]    sync_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= 2'b11;
         cnt_q  <= '0;
         dout   <= 1'b1;
      end else begin
         sync_q <= {sync_q[0], din};
         if (sync_q[1] != dout) begin
            if (cnt_q == CW'(FILT_LEN - 1)) begin
               dout  <= sync_q[1];
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            cnt_q <= '0;
         end
      end
   end

   // R9: the filtered level only ever moves to the synchronized input level
   p_filter_settle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dout != $past(dout)) |-> (dout == $past(sync_q[1])));

endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events #(
   parameter int FILT_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic [1:0] raw, filt, prev_q;

   assign raw = {scl_i, sda_i};

   for (genvar i = 0; i < 2; i++) begin : g_line
      twi_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (raw[i]),
         .dout (filt[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 2'b11;
      else        prev_q <= filt;
   end

   assign scl_lvl  = filt[1];
   assign sda_lvl  = filt[0];
   assign scl_rise = filt[1] & ~prev_q[1];
   assign scl_fall = ~filt[1] & prev_q[1];
   assign start_ev = filt[1] & prev_q[1] & prev_q[0] & ~filt[0];
   assign stop_ev  = filt[1] & prev_q[1] & ~prev_q[0] & filt[0];

endmodule

// File: rtl/twi_page_mem.sv
module twi_page_mem #(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-PAGE_W-1:0] wr_page,
   input  logic [(1<<PAGE_W)-1:0]   wr_mask,
   input  logic [8*(1<<PAGE_W)-1:0] wr_data,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [7:0]               rd_data
);
   localparam int LANES = 1 << PAGE_W;
   localparam int DEPTH = 1 << ADDR_W;
   localparam int PGW   = ADDR_W - PAGE_W;

   logic [7:0] bytes [DEPTH];

   for (genvar a = 0; a < DEPTH; a++) begin : g_byte
      localparam int LANE = a % LANES;
      localparam int PG   = a / LANES;
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 8'h00;
         else if (wr_en && wr_page == PGW'(PG) && wr_mask[LANE])
            q <= wr_data[8*LANE +: 8];
      end
      assign bytes[a] = q;
   end

   assign rd_data = bytes[rd_addr];

endmodule

// File: rtl/twi_mem_target.sv
module twi_mem_target
   import twi_mem_pkg::*;
#(
   parameter int         ADDR_W    = 8,
   parameter int         PAGE_W    = 4,
   parameter int         FILT_LEN  = 4,
   parameter int         WR_CYCLES = 500000,
   parameter logic [3:0] TYPE_CODE = 4'b1010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] strap_i,
   output logic       sda_oe_o
);
   localparam int LANES = 1 << PAGE_W;
   localparam int BW    = $clog2(WR_CYCLES + 1);

   if (PAGE_W >= ADDR_W || ADDR_W > 8) begin : g_bad_geom
      $error("twi_mem_target: need PAGE_W < ADDR_W <= 8");
   end
   if (FILT_LEN < 2) begin : g_bad_filt
      $error("twi_mem_target: FILT_LEN must be at least 2");
   end
   if (WR_CYCLES < 1) begin : g_bad_wr
      $error("twi_mem_target: WR_CYCLES must be at least 1");
   end

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, ev_start, ev_stop;

   twi_bus_events #(.FILT_LEN(FILT_LEN)) u_events (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (scl_i),
      .sda_i   (sda_i),
      .scl_lvl (scl_lvl),
      .sda_lvl (sda_lvl),
      .scl_rise(scl_rise),
      .scl_fall(scl_fall),
      .start_ev(ev_start),
      .stop_ev (ev_stop)
   );

   twi_state_t            st;
   twi_kind_t             kind;
   logic [3:0]            bitcnt;
   logic [7:0]            shreg, tx;
   logic [ADDR_W-1:0]     ptr;
   logic [8*LANES-1:0]    wbuf;
   logic [LANES-1:0]      wvalid;
   logic                  rd_mode, mnack, sda_oe;
   logic [BW-1:0]         busy_cnt;
   logic                  busy, commit_now;
   logic [7:0]            rd_data;

   assign busy       = (busy_cnt != '0);
   assign commit_now = ev_stop && !busy && st == ST_RX && kind == K_DATA &&
                       bitcnt == 4'd1 && (|wvalid);
   assign sda_oe_o   = sda_oe;

   twi_page_mem #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_mem (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (commit_now),
      .wr_page(ptr[ADDR_W-1:PAGE_W]),
      .wr_mask(wvalid),
      .wr_data(wbuf),
      .rd_addr(ptr),
      .rd_data(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         kind     <= K_DEV;
         bitcnt   <= '0;
         shreg    <= '0;
         tx       <= '0;
         ptr      <= '0;
         wbuf     <= '0;
         wvalid   <= '0;
         rd_mode  <= 1'b0;
         mnack    <= 1'b1;
         sda_oe   <= 1'b0;
         busy_cnt <= '0;
      end else begin
         if (busy) busy_cnt <= busy_cnt - 1'b1;
         if (commit_now) busy_cnt <= BW'(WR_CYCLES);
         if (busy) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (ev_start) begin
            st     <= ST_RX;
            kind   <= K_DEV;
            bitcnt <= '0;
            sda_oe <= 1'b0;
            wvalid <= '0;
         end else if (ev_stop) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
            wvalid <= '0;
         end else begin
            case (st)
               ST_RX: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[6:0], sda_lvl};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     bitcnt <= '0;
                     case (kind)
                        K_DEV: begin
                           if (shreg[7:1] == {TYPE_CODE, strap_i}) begin
                              sda_oe  <= 1'b1;
                              st      <= ST_ACK;
                              rd_mode <= shreg[0];
                              kind    <= K_ADDR;
                           end else begin
                              st <= ST_IDLE;
                           end
                        end
                        K_ADDR: begin
                           ptr    <= shreg[ADDR_W-1:0];
                           kind   <= K_DATA;
                           sda_oe <= 1'b1;
                           st     <= ST_ACK;
                        end
                        default: begin
                           wbuf[8*ptr[PAGE_W-1:0] +: 8] <= shreg;
                           wvalid[ptr[PAGE_W-1:0]]      <= 1'b1;
                           ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
                           sda_oe <= 1'b1;
                           st     <= ST_ACK;
                        end
                     endcase
                  end
               end
               ST_ACK, ST_MACK: begin
                  if (st == ST_MACK && scl_rise) mnack <= sda_lvl;
                  if (scl_fall) begin
                     if (st == ST_MACK && mnack) begin
                        st <= ST_IDLE;
                     end else if (rd_mode) begin
                        tx     <= rd_data;
                        ptr    <= ptr + 1'b1;
                        sda_oe <= ~rd_data[7];
                        bitcnt <= '0;
                        st     <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall) begin
                     if (bitcnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        mnack  <= 1'b1;
                        st     <= ST_MACK;
                     end else begin
                        tx     <= {tx[6:0], 1'b0};
                        sda_oe <= ~tx[6];
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R10: SDA drive moves only while the filtered clock is low
   p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !$past(scl_lvl));

   // R4: programming interval keeps the data line released
   p_busy_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe);

   // R5: transmit states are reached only for a read-direction address
   p_tx_readonly_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TX || st == ST_MACK) |-> rd_mode);

   // R1: an acknowledge follows exactly eight received bits
   p_ack_ninth_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_oe) && st == ST_ACK) |-> ($past(st) == ST_RX && $past(bitcnt) == 4'd8));

endmodule

// File: tb/twi_mem_target_bench.sv
module twi_mem_target_bench;
   localparam int CLK_PERIOD = 10;
   localparam int QTR        = 20;
   localparam int WR         = 400;
   localparam logic [2:0] STRAP = 3'b101;

   logic clk = 1'b0;
   logic rst_n;
   logic m_scl, m_sda;
   logic sda_oe;
   logic sda_line;
   int   total = 0;
   int   fails = 0;
   int   viol  = 0;
   logic oe_prev = 1'b0;
   logic [7:0] model [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line = m_sda & ~sda_oe;

   twi_mem_target #(.FILT_LEN(4), .WR_CYCLES(WR)) u_twi_mem_target (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (m_scl),
      .sda_i   (sda_line),
      .strap_i (STRAP),
      .sda_oe_o(sda_oe)
   );

   // R10 monitor: drive changes must fall inside SCL-low time
   always @(negedge clk) begin
      if (rst_n && sda_oe !== oe_prev && m_scl) viol++;
      oe_prev = sda_oe;
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic q();
      repeat (QTR) @(negedge clk);
   endtask

   task automatic do_start();
      m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
   endtask

   task automatic do_stop();
      m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q(); q();
   endtask

   task automatic send_bit(input logic b, input bit glitch);
      m_sda = b; q(); m_scl = 1'b1;
      if (glitch) begin
         repeat (8) @(negedge clk);
         m_sda = 1'b0;
         repeat (2) @(negedge clk);
         m_sda = 1'b1;
         repeat (2*QTR - 10) @(negedge clk);
      end else begin
         q(); q();
      end
      m_scl = 1'b0; q();
   endtask

   task automatic recv_bit(output logic b);
      m_sda = 1'b1; q(); m_scl = 1'b1; q();
      b = sda_line;
      q(); m_scl = 1'b0; q();
   endtask

   task automatic send_byte(input logic [7:0] v, input bit glitch, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(v[i], glitch && i == 7);
      recv_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         v[i] = b;
      end
      send_bit(~give_ack, 1'b0);
   endtask

   task automatic dev(input logic rw, input int exp_ack, input string req);
      logic ack;
      send_byte({4'b1010, STRAP, rw}, 1'b0, ack);
      check(req, int'(ack), exp_ack);
   endtask

   task automatic write_seq(input logic [7:0] a, input int n, input logic [7:0] seed,
                            input string req);
      logic ack;
      logic [7:0] v;
      do_start();
      dev(1'b0, 1, req);
      send_byte(a, 1'b0, ack);
      check(req, int'(ack), 1);
      for (int i = 0; i < n; i++) begin
         v = seed + 8'(7 * i);
         send_byte(v, 1'b0, ack);
         check(req, int'(ack), 1);
         model[{a[7:4], 4'(a[3:0] + 4'(i))}] = v;
      end
      do_stop();
   endtask

   task automatic rand_read(input logic [7:0] a, input int n, input string req);
      logic ack;
      logic [7:0] v;
      do_start();
      dev(1'b0, 1, req);
      send_byte(a, 1'b0, ack);
      check(req, int'(ack), 1);
      do_start();
      dev(1'b1, 1, req);
      for (int i = 0; i < n; i++) begin
         recv_byte(i < n - 1, v);
         check(req, int'(v), int'(model[8'(a + 8'(i))]));
      end
      do_stop();
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_up();
   end

   initial begin
      logic ack;
      logic [7:0] v;
      logic [6:0] id;
      m_scl = 1'b1;
      m_sda = 1'b1;
      rst_n = 1'b0;
      for (int i = 0; i < 256; i++) model[i] = 8'h00;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      check("R11 reset drive", int'(sda_oe), 0);

      // R1: strap sweep and wrong type codes
      for (int t = 0; t < 12; t++) begin
         if (t < 8) id = {4'b1010, 3'(t)};
         else       id = {4'b1010 ^ 4'(1 << (t - 8)), STRAP};
         do_start();
         send_byte({id, 1'b0}, 1'b0, ack);
         check("R1", int'(ack), int'(id == {4'b1010, STRAP}));
         do_stop();
      end

      rand_read(8'h40, 1, "R11");

      // R2 / R4: single byte, busy poll, then read back
      write_seq(8'h37, 1, 8'hA5, "R2");
      do_start();
      dev(1'b0, 0, "R4 busy");
      do_stop();
      repeat (WR + 100) @(negedge clk);
      do_start();
      dev(1'b0, 1, "R4 after");
      do_stop();
      rand_read(8'h37, 1, "R2");

      // R3: page write overrunning the page
      write_seq(8'h35, 18, 8'h10, "R3");
      repeat (WR + 100) @(negedge clk);
      rand_read(8'h30, 16, "R3");

      // R5 / R6: wrap 255->0 then current-address reads
      write_seq(8'hFE, 2, 8'hC0, "R5");
      repeat (WR + 100) @(negedge clk);
      rand_read(8'hFE, 3, "R6");
      do_start();
      dev(1'b1, 1, "R6");
      recv_byte(1'b0, v);
      check("R6 current", int'(v), int'(model[1]));
      do_stop();
      repeat (10) @(negedge clk);
      check("R7 released", int'(sda_oe), 0);
      do_start();
      dev(1'b1, 1, "R7");
      recv_byte(1'b0, v);
      check("R7 next", int'(v), int'(model[2]));
      do_stop();

      // R8: stop mid-byte discards data, no busy
      do_start();
      dev(1'b0, 1, "R8");
      send_byte(8'h50, 1'b0, ack);
      send_byte(8'h77, 1'b0, ack);
      check("R8", int'(ack), 1);
      for (int i = 0; i < 4; i++) send_bit(i[0], 1'b0);
      do_stop();
      do_start();
      dev(1'b0, 1, "R8 not busy");
      do_stop();
      rand_read(8'h50, 2, "R8");

      // R8 / R5: repeated start abandons write, reads at pointer
      do_start();
      dev(1'b0, 1, "R8");
      send_byte(8'h60, 1'b0, ack);
      send_byte(8'h99, 1'b0, ack);
      do_start();
      dev(1'b1, 1, "R5");
      recv_byte(1'b0, v);
      check("R5 pointer", int'(v), int'(model[8'h61]));
      do_stop();
      rand_read(8'h60, 1, "R8");

      // R9: short SDA dip while SCL high is not a START
      do_start();
      send_byte({4'b1010, STRAP, 1'b0}, 1'b1, ack);
      check("R9 glitch", int'(ack), 1);
      send_byte(8'h37, 1'b0, ack);
      do_start();
      dev(1'b1, 1, "R9");
      recv_byte(1'b0, v);
      check("R9 data", int'(v), int'(model[8'h37]));
      do_stop();

      check("R10 drive timing", viol, 0);
      finish_up();
   end
endmodule